// File: doc/BRIEF.md
# UART Register and Interrupt-Priority Controller

This block is the software-visible face of a 16550-style serial port. A processor reaches it through a 32-bit port. Each access selects one of eight word-indexed registers. Through them it configures the line and modem settings and the baud divisor, and it reads the line and modem status. It also takes the most recently received byte and queues bytes for transmission. The serial shift engine, baud generator, parity logic and modem pin sampling sit outside this block.

The receive side accepts a byte with a valid/ready handshake and holds one byte. Software reads the byte to drain it. If a second byte arrives before that read, the new byte replaces the old one and an overrun is recorded. The parity, framing and break conditions come in as single-cycle pulses from the external engine. The modem status byte comes in as a plain input. A fixed four-level priority encoder combines the status with the enable register. It drives one level-sensitive interrupt line and a 3-bit identification code that software can read.

Top module: `uart_regctl`

## Requirements
- R1: Index 0 reads the held receive byte in bits 7:0. Index 2 reads the identification code in bits 2:0. Index 5 reads line status in bits 6:0. Index 6 reads the modem status input in bits 7:0. All other bits read zero, and the read port reads zero when no read is in progress.
- R2: Line status bits are 0 data ready, 1 overrun, 2 parity error, 3 framing error, 4 break, 5 transmit holding empty and 6 transmitter empty. After reset it reads 0x60, every other register reads zero and the interrupt is low.
- R3: A full read of index 0 clears data ready on the next clock edge, unless a new byte arrives in the same cycle.
- R4: A byte that arrives while data ready is set sets overrun, replaces the held byte and leaves data ready set.
- R5: `rx_ready_o` is high exactly while data ready is clear.
- R6: A pulse on the parity, framing or break input sets line status bit 2, 3 or 4 respectively. These bits and overrun stay set until reset.
- R7: Interrupt-enable bits are 0 receive data, 1 transmit holding empty, 2 line status error and 3 modem status. The enabled sources rank in this order, highest first:
  - any error bit gives identification 3'b110;
  - data ready gives 3'b100;
  - transmit holding empty gives 3'b010;
  - a nonzero modem status bit 3:0 gives 3'b000.
  
  The interrupt is high while any enabled source is active.
- R8: With no enabled source active, the identification reads 3'b001 and the interrupt is low.
- R9: Indices 1 (interrupt enable), 3 (line control), 4 (modem control) and 7 (divisor) store writes and read back as zero. Line control, modem control and divisor appear on `line_cfg_o`, `modem_cfg_o` and `divisor_o` from the cycle after the write.
- R10: Writes to indices 2, 5 and 6 change nothing.
- R11: An access whose byte enables are not all set has no effect. It stores nothing, clears nothing, sends nothing and reads zero.
- R12: A full write to index 0 raises `tx_strobe_o` for exactly the next cycle, with the low byte of the write data on `tx_byte_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Register access this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_idx_i | input | 3 | Word index of the register |
| bus_be_i | input | 4 | Byte enables; only all-ones is honoured |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the access cycle |
| rx_byte_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | Received byte present |
| rx_ready_o | output | 1 | Holding byte is empty |
| tx_byte_o | output | 8 | Byte to transmit |
| tx_strobe_o | output | 1 | One-cycle transmit request |
| par_err_i | input | 1 | Parity error pulse |
| frm_err_i | input | 1 | Framing error pulse |
| brk_i | input | 1 | Break detected pulse |
| modem_stat_i | input | 8 | Modem status byte |
| line_cfg_o | output | 8 | Stored line control |
| modem_cfg_o | output | 8 | Stored modem control |
| divisor_o | output | 16 | Stored baud divisor |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the byte source may ignore `rx_ready_o`, which is what makes overrun reachable. They also assume that error pulses and modem status can change on any cycle and that the bus issues at most one access per cycle. The stimulus respects those limits. It deliberately pushes bytes while data ready is set, including in the same cycle as a drain read. It also mixes partial byte-enable accesses with full ones. Each cycle a behavioural model in the bench predicts the read data, interrupt, ready and transmit outputs. A mid-run reset clears the sticky error bits so that every priority level can be reached in turn.

// File: rtl/ucr_pkg.sv
package ucr_pkg;
    localparam int IDX_W = 3;
    localparam int IID_W = 3;

    typedef enum logic [IDX_W-1:0] {
        IDX_DATA  = 3'd0,
        IDX_IEN   = 3'd1,
        IDX_IID   = 3'd2,
        IDX_LCTL  = 3'd3,
        IDX_MCTL  = 3'd4,
        IDX_LSTAT = 3'd5,
        IDX_MSTAT = 3'd6,
        IDX_DIV   = 3'd7
    } reg_idx_e;

    localparam logic [IID_W-1:0] IID_LINE  = 3'b110;
    localparam logic [IID_W-1:0] IID_RXD   = 3'b100;
    localparam logic [IID_W-1:0] IID_THR   = 3'b010;
    localparam logic [IID_W-1:0] IID_MODEM = 3'b000;
    localparam logic [IID_W-1:0] IID_NONE  = 3'b001;

    localparam int IEN_RXD   = 0;
    localparam int IEN_THR   = 1;
    localparam int IEN_LINE  = 2;
    localparam int IEN_MODEM = 3;
    localparam int IEN_W     = 4;
endpackage

// File: rtl/ucr_rx_hold.sv
module ucr_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              rx_valid_i,
    input  logic              take_i,
    input  logic              perr_i,
    input  logic              ferr_i,
    input  logic              brk_i,
    output logic [DATA_W-1:0] data_o,
    output logic              dr_o,
    output logic              oe_o,
    output logic              pe_o,
    output logic              fe_o,
    output logic              bi_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              dr;
        logic              oe;
        logic              pe;
        logic              fe;
        logic              bi;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rx_valid_i) begin
            st_d.oe   = st_q.oe | st_q.dr;
            st_d.data = rx_byte_i;
            st_d.dr   = 1'b1;
        end else if (take_i) begin
            st_d.dr = 1'b0;
        end
        st_d.pe = st_q.pe | perr_i;
        st_d.fe = st_q.fe | ferr_i;
        st_d.bi = st_q.bi | brk_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign dr_o   = st_q.dr;
    assign oe_o   = st_q.oe;
    assign pe_o   = st_q.pe;
    assign fe_o   = st_q.fe;
    assign bi_o   = st_q.bi;

    logic [3:0] errs;
    assign errs = {st_q.oe, st_q.pe, st_q.fe, st_q.bi};

    AST_OVERRUN_ON_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && dr_o) |=> (oe_o && dr_o)); // R4
    AST_READ_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_i && !rx_valid_i) |=> !dr_o); // R3
    AST_ERRORS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (errs != 4'd0) |=> ((errs & $past(errs)) == $past(errs))); // R6
endmodule

// File: rtl/ucr_cfg_regs.sv
module ucr_cfg_regs
    import ucr_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int LCTL_W = 8,
    parameter int MCTL_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [IEN_W-1:0]  ien_o,
    output logic [LCTL_W-1:0] lctl_o,
    output logic [MCTL_W-1:0] mctl_o,
    output logic [DIV_W-1:0]  div_o
);
    typedef struct packed {
        logic [IEN_W-1:0]  ien;
        logic [LCTL_W-1:0] lctl;
        logic [MCTL_W-1:0] mctl;
        logic [DIV_W-1:0]  div;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            unique case (reg_idx_e'(idx_i))
                IDX_IEN:  cfg_d.ien  = wdata_i[IEN_W-1:0];
                IDX_LCTL: cfg_d.lctl = wdata_i[LCTL_W-1:0];
                IDX_MCTL: cfg_d.mctl = wdata_i[MCTL_W-1:0];
                IDX_DIV:  cfg_d.div  = wdata_i[DIV_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign ien_o  = cfg_q.ien;
    assign lctl_o = cfg_q.lctl;
    assign mctl_o = cfg_q.mctl;
    assign div_o  = cfg_q.div;

    AST_CFG_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(div_o) && $stable(ien_o)); // R10
endmodule

// File: rtl/ucr_irq_prio.sv
module ucr_irq_prio
    import ucr_pkg::*;
(
    input  logic             line_err_i,
    input  logic             dr_i,
    input  logic             thre_i,
    input  logic [3:0]       modem_low_i,
    input  logic [IEN_W-1:0] ien_i,
    output logic             irq_o,
    output logic [IID_W-1:0] iid_o
);
    always_comb begin
        irq_o = 1'b1;
        if (line_err_i && ien_i[IEN_LINE])              iid_o = IID_LINE;
        else if (dr_i && ien_i[IEN_RXD])                iid_o = IID_RXD;
        else if (thre_i && ien_i[IEN_THR])              iid_o = IID_THR;
        else if ((|modem_low_i) && ien_i[IEN_MODEM])    iid_o = IID_MODEM;
        else begin
            iid_o = IID_NONE;
            irq_o = 1'b0;
        end
    end
endmodule

// File: rtl/uart_regctl.sv
module uart_regctl
    import ucr_pkg::*;
#(
    parameter int BUS_W  = 32,
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel_i,
    input  logic              bus_we_i,
    input  logic [IDX_W-1:0]  bus_idx_i,
    input  logic [BUS_W/8-1:0] bus_be_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              rx_valid_i,
    output logic              rx_ready_o,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic              tx_strobe_o,
    input  logic              par_err_i,
    input  logic              frm_err_i,
    input  logic              brk_i,
    input  logic [7:0]        modem_stat_i,
    output logic [7:0]        line_cfg_o,
    output logic [7:0]        modem_cfg_o,
    output logic [DIV_W-1:0]  divisor_o,
    output logic              irq_o
);
    localparam int LSTAT_W = 7;

    logic full_acc, rd_hit, wr_hit, take_data, send_data;
    assign full_acc  = bus_sel_i && (&bus_be_i);
    assign rd_hit    = full_acc && !bus_we_i;
    assign wr_hit    = full_acc && bus_we_i;
    assign take_data = rd_hit && (bus_idx_i == IDX_DATA);
    assign send_data = wr_hit && (bus_idx_i == IDX_DATA);

    logic [DATA_W-1:0] held;
    logic dr, oe, pe, fe, bi;

    ucr_rx_hold #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n),
        .rx_byte_i(rx_byte_i), .rx_valid_i(rx_valid_i), .take_i(take_data),
        .perr_i(par_err_i), .ferr_i(frm_err_i), .brk_i(brk_i),
        .data_o(held), .dr_o(dr), .oe_o(oe), .pe_o(pe), .fe_o(fe), .bi_o(bi)
    );

    logic [IEN_W-1:0] ien;

    ucr_cfg_regs #(.BUS_W(BUS_W), .LCTL_W(8), .MCTL_W(8), .DIV_W(DIV_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_hit), .idx_i(bus_idx_i), .wdata_i(bus_wdata_i),
        .ien_o(ien), .lctl_o(line_cfg_o), .mctl_o(modem_cfg_o), .div_o(divisor_o)
    );

    // Transmit holding is always free: no shift engine in this block.
    logic thre, temt, line_err;
    assign thre     = 1'b1;
    assign temt     = 1'b1;
    assign line_err = oe | pe | fe | bi;

    logic [IID_W-1:0] iid;

    ucr_irq_prio u_prio (
        .line_err_i(line_err), .dr_i(dr), .thre_i(thre),
        .modem_low_i(modem_stat_i[3:0]), .ien_i(ien),
        .irq_o(irq_o), .iid_o(iid)
    );

    typedef struct packed {
        logic              strobe;
        logic [DATA_W-1:0] byte_v;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d        = tx_q;
        tx_d.strobe = send_data;
        if (send_data) tx_d.byte_v = bus_wdata_i[DATA_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign tx_strobe_o = tx_q.strobe;
    assign tx_byte_o   = tx_q.byte_v;
    assign rx_ready_o  = !dr;

    logic [LSTAT_W-1:0] lstat;
    assign lstat = {temt, thre, bi, fe, pe, oe, dr};

    always_comb begin
        bus_rdata_o = '0;
        if (rd_hit) begin
            unique case (reg_idx_e'(bus_idx_i))
                IDX_DATA:  bus_rdata_o[DATA_W-1:0]  = held;
                IDX_IID:   bus_rdata_o[IID_W-1:0]   = iid;
                IDX_LSTAT: bus_rdata_o[LSTAT_W-1:0] = lstat;
                IDX_MSTAT: bus_rdata_o[7:0]         = modem_stat_i;
                default:   ;
            endcase
        end
    end

    logic unused_modem_hi;
    assign unused_modem_hi = ^modem_stat_i[7:4];

    AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_strobe_o |-> $past(send_data)); // R12
    AST_LINE_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (line_err && ien[IEN_LINE]) |-> (irq_o && iid == IID_LINE)); // R7
    AST_NO_SRC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (iid == IID_NONE) |-> !irq_o); // R8
    AST_READY_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (take_data && !rx_valid_i) |=> rx_ready_o); // R5
endmodule

// File: tb/uart_regctl_tb.sv
`timescale 1ns/1ps
module uart_regctl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 0, we = 0;
    logic [2:0]  idx = 0;
    logic [3:0]  be = 0;
    logic [31:0] wdata = 0;
    logic [31:0] rdata;
    logic [7:0]  rxb = 0;
    logic        rxv = 0;
    logic        rdy;
    logic [7:0]  txb;
    logic        txs;
    logic        perr = 0, ferr = 0, brk = 0;
    logic [7:0]  ms = 0;
    logic [7:0]  lcfg, mcfg;
    logic [15:0] dv;
    logic        irq;

    always #10 clk = ~clk;

    uart_regctl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel_i(sel), .bus_we_i(we), .bus_idx_i(idx),
        .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .rx_byte_i(rxb), .rx_valid_i(rxv), .rx_ready_o(rdy),
        .tx_byte_o(txb), .tx_strobe_o(txs),
        .par_err_i(perr), .frm_err_i(ferr), .brk_i(brk), .modem_stat_i(ms),
        .line_cfg_o(lcfg), .modem_cfg_o(mcfg), .divisor_o(dv), .irq_o(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    string rd_tag = "R1";

    // behavioural reference state
    bit        m_dr, m_oe, m_pe, m_fe, m_bi, m_txs;
    bit [7:0]  m_rx, m_txb, m_lcr, m_mcr;
    bit [3:0]  m_ier;
    bit [15:0] m_div;

    function automatic bit [2:0] exp_iid();
        if ((m_oe || m_pe || m_fe || m_bi) && m_ier[2]) return 3'b110;
        if (m_dr && m_ier[0]) return 3'b100;
        if (m_ier[1]) return 3'b010;
        if ((ms[3:0] != 0) && m_ier[3]) return 3'b000;
        return 3'b001;
    endfunction

    function automatic bit [31:0] exp_rdata();
        if (!(sel && !we && be == 4'hF)) return 0;
        case (idx)
            3'd0: return {24'd0, m_rx};
            3'd2: return {29'd0, exp_iid()};
            3'd5: return {25'd0, 1'b1, 1'b1, m_bi, m_fe, m_pe, m_oe, m_dr};
            3'd6: return {24'd0, ms};
            default: return 0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_dr = 0; m_oe = 0; m_pe = 0; m_fe = 0; m_bi = 0; m_txs = 0;
        m_rx = 0; m_txb = 0; m_lcr = 0; m_mcr = 0; m_ier = 0; m_div = 0;
    endtask

    // Check in the low phase, then advance the model past the rising edge.
    task automatic cyc();
        bit hit;
        #2;
        if (rst_n) begin
            chk(rd_tag, rdata, exp_rdata());
            chk("R7 irq level", {31'd0, irq}, {31'd0, exp_iid() != 3'b001});
            chk("R5 rx_ready", {31'd0, rdy}, {31'd0, !m_dr});
            chk("R12 tx_strobe", {31'd0, txs}, {31'd0, m_txs});
            if (m_txs) chk("R12 tx_byte", {24'd0, txb}, {24'd0, m_txb});
            chk("R9 cfg outputs", {lcfg, mcfg, dv}, {m_lcr, m_mcr, m_div});
        end
        @(posedge clk);
        if (!rst_n) model_reset();
        else begin
            hit = sel && be == 4'hF;
            m_txs = 0;
            if (rxv) begin
                m_oe = m_oe | m_dr; m_rx = rxb; m_dr = 1;
            end else if (hit && !we && idx == 0) m_dr = 0;
            m_pe |= perr; m_fe |= ferr; m_bi |= brk;
            if (hit && we) begin
                case (idx)
                    3'd0: begin m_txs = 1; m_txb = wdata[7:0]; end
                    3'd1: m_ier = wdata[3:0];
                    3'd3: m_lcr = wdata[7:0];
                    3'd4: m_mcr = wdata[7:0];
                    3'd7: m_div = wdata[15:0];
                    default: ;
                endcase
            end
        end
        @(negedge clk);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic rd(bit [2:0] i, string tag, bit [3:0] b = 4'hF);
        sel = 1; we = 0; idx = i; be = b; rd_tag = tag;
        cyc();
        sel = 0; be = 0; rd_tag = "R1";
    endtask

    task automatic wr(bit [2:0] i, bit [31:0] d, bit [3:0] b = 4'hF);
        sel = 1; we = 1; idx = i; be = b; wdata = d;
        cyc();
        sel = 0; we = 0; be = 0; wdata = 0;
    endtask

    task automatic push(bit [7:0] b);
        rxb = b; rxv = 1; cyc(); rxv = 0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        idle(2);
        // R2: reset values of every index
        for (int i = 0; i < 8; i++) rd(3'(i), "R2 reset readback");

        // R1 / R3: receive and drain
        push(8'hA5);
        rd(3'd5, "R1 lstat with data");
        rd(3'd0, "R1 data byte");
        rd(3'd5, "R3 data ready cleared");

        // R9: write-only registers store and read zero
        wr(3'd3, 32'hFFFF_FF5A);
        wr(3'd4, 32'h0000_0003);
        wr(3'd7, 32'hDEAD_1234);
        wr(3'd1, 32'h0000_0001);
        rd(3'd1, "R9 ien reads zero");
        rd(3'd3, "R9 lctl reads zero");
        rd(3'd7, "R9 div reads zero");

        // R7: receive data interrupt
        push(8'h3C);
        rd(3'd2, "R7 iid rx data");
        rd(3'd0, "R3 drain");
        rd(3'd2, "R8 iid none");

        // R4: overrun
        push(8'h11);
        push(8'h22);
        rd(3'd5, "R4 overrun set");
        rd(3'd0, "R4 newest byte");
        rd(3'd5, "R4 overrun sticky");

        // R6: error pulses
        perr = 1; cyc(); perr = 0;
        ferr = 1; cyc(); ferr = 0;
        brk = 1; cyc(); brk = 0;
        idle(2);
        rd(3'd5, "R6 errors held");

        // R10: writes to status indices ignored
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd5, 32'h0000_0000);
        ms = 8'h5A;
        wr(3'd6, 32'h0000_0000);
        rd(3'd5, "R10 lstat unchanged");
        rd(3'd6, "R10 mstat follows input");
        rd(3'd2, "R10 iid unchanged");

        // R11: partial accesses ignored
        push(8'h77);
        rd(3'd0, "R11 partial read zero", 4'h1);
        rd(3'd5, "R11 data ready kept");
        wr(3'd7, 32'h0000_BEEF, 4'h3);
        wr(3'd0, 32'h0000_0099, 4'hE);
        idle(1);

        // R12: transmit strobe
        wr(3'd0, 32'h1234_56C3);
        idle(1);
        wr(3'd0, 32'h0000_0001);
        wr(3'd0, 32'h0000_0002);
        idle(2);

        // same-cycle arrival and drain: old byte read, overrun set
        sel = 1; we = 0; idx = 0; be = 4'hF; rd_tag = "R4 collide read";
        rxb = 8'hE1; rxv = 1;
        cyc();
        sel = 0; be = 0; rxv = 0; rd_tag = "R1";
        rd(3'd0, "R4 collide new byte");

        // R7 priority ladder after clearing sticky errors
        rst_n = 0; cyc(); rst_n = 1;
        rd(3'd5, "R2 lstat after reset");
        ms = 8'h03;
        wr(3'd1, 32'h8);
        rd(3'd2, "R7 iid modem");
        wr(3'd1, 32'hA);
        rd(3'd2, "R7 iid thr over modem");
        push(8'h44);
        wr(3'd1, 32'hB);
        rd(3'd2, "R7 iid rx over thr");
        perr = 1; cyc(); perr = 0;
        wr(3'd1, 32'hF);
        rd(3'd2, "R7 iid line first");
        wr(3'd1, 32'h0);
        ms = 8'h00;
        rd(3'd2, "R8 iid none, errors masked");
        ms = 8'hF0;
        wr(3'd1, 32'h8);
        rd(3'd2, "R8 modem high nibble no source");
        idle(3);
        summary();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end
endmodule